// File: doc/BRIEF.md
# Token Marking Controller for a Bottle-Filling Conveyor

This block runs a five-place, signal-driven Petri net that sequences a conveyor bottle-filling station. It samples six binary signals: start and stop from the operator, tank low and tank high from the tank level switches, and bottle present and bottle full from the conveyor. It keeps a token count for every place. Transitions fire under Boolean guards built from the sampled signals. The tank fill valve, the conveyor motor and the bottle fill valve are driven from the places that hold tokens.

Each time the marking is stable, the inputs are captured into a holding register. After that the controller performs one firing step per clock, with the captured values frozen, until no transition can fire. The three actuator outputs and the settled flag change only when an evaluation finds that nothing can fire. Conflicts are settled inside the guards: stop overrides every competing move. Where several transitions draw on the same place, a fixed grant order decides which ones fire. A settling window that keeps firing for too long raises a sticky error.

Top module: `pn_token_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller loads 2 tokens into Run and 0 into every other place, and clears all three actuator outputs, `settled` and `settle_err`.
- R2: `tokens` holds the count of place p in bits [2p+1:2p], with places indexed Run=0, TankFill=1, Motor=2, BottleFill=3, Idle=4. The counts always sum to 2, and TankFill, Motor and BottleFill each hold at most 1.
- R3: Each move has one source and one destination. Idle→Run fires on start. Run→TankFill fires on tank low. Run→Motor fires when no bottle is present. Run→BottleFill fires when a bottle is present. TankFill→Run fires on tank high. Motor→BottleFill fires when a bottle is present and not full. BottleFill→Motor fires when the bottle is full. Run, TankFill, Motor and BottleFill each move to Idle on stop.
- R4: A move fires only if its source holds a token and its destination stays within capacity. Run and Idle have a capacity of 2, the other places 1. Tokens granted to the destination earlier in the same step count against that capacity. Each move fires at most once per step.
- R5: Moves are granted in a fixed order: all stop-driven moves first, then the rest in ascending index. A place never gives up more tokens in a step than it held at the start of that step.
- R6: While the captured stop is high, only the stop-driven moves and Idle→Run can fire.
- R7: One firing step happens per clock. The input values used by all steps of one settling window are the ones captured when the window opened.
- R8: `tank_valve`, `run_motor` and `fill_valve` reflect TankFill, Motor and BottleFill respectively, and change only at a settled evaluation.
- R9: `settled` rises when an evaluation finds no move can fire and falls on the next firing step.
- R10: If 16 firing steps occur in one settling window, `settle_err` sets and stays set until reset, the window is abandoned and the outputs keep their values.
- R11: Run→Motor and Run→BottleFill never fire in the same step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operator start |
| stop | input | 1 | Operator stop |
| tank_low | input | 1 | Tank at lower level |
| tank_high | input | 1 | Tank at upper level |
| bottle_in | input | 1 | Bottle in position |
| bottle_full | input | 1 | Bottle full |
| tank_valve | output | 1 | Tank fill valve drive |
| run_motor | output | 1 | Conveyor motor drive |
| fill_valve | output | 1 | Bottle fill valve drive |
| settled | output | 1 | Marking stable at the last evaluation |
| settle_err | output | 1 | Sticky settling-timeout error |
| tokens | output | 10 | Current marking, 2 bits per place |

## Verification
The assertions check the following on every cycle: tokens are conserved, no single-token place overflows, the actuator outputs change only together with a settled flag, captured inputs stay fixed within a window, the two bottle-dependent moves out of Run are mutually exclusive, stop gates the ordinary moves, and the timeout error is sticky. The scenarios carry the sequencing meaning, which the assertions cannot express. They check the exact marking reached after multi-step settling, the blocking of a second token by a full destination, two stop moves sharing the Idle capacity, stop winning over tank high on the same sample, and a tank-low/tank-high ping-pong that runs into the timeout.

// File: rtl/pn_pkg.sv
// Package: place and transition indices, the arc table and the sampled
// sensor type shared by the token controller. Assumes a fixed five-place
// net; token width is chosen by the top from its TOKENS parameter.
package pn_pkg;

    localparam int NPLACE = 5;
    localparam int NTRANS = 11;

    // Place indices (also the field order of the tokens port)
    localparam int PL_RUN   = 0;
    localparam int PL_TANK  = 1;
    localparam int PL_MOTOR = 2;
    localparam int PL_FILL  = 3;
    localparam int PL_IDLE  = 4;

    // Transition indices; the ascending order is the grant order of
    // the ordinary moves
    localparam int TR_RESUME     = 0;  // Idle  -> Run
    localparam int TR_TANK_FILL  = 1;  // Run   -> TankFill
    localparam int TR_NO_BOTTLE  = 2;  // Run   -> Motor
    localparam int TR_BOTTLE     = 3;  // Run   -> BottleFill
    localparam int TR_HALT_RUN   = 4;  // Run   -> Idle
    localparam int TR_TANK_DONE  = 5;  // TankFill -> Run
    localparam int TR_HALT_TANK  = 6;  // TankFill -> Idle
    localparam int TR_HALT_MOTOR = 7;  // Motor -> Idle
    localparam int TR_HALT_FILL  = 8;  // BottleFill -> Idle
    localparam int TR_TO_FILL    = 9;  // Motor -> BottleFill
    localparam int TR_TO_MOTOR   = 10; // BottleFill -> Motor

    typedef struct packed {
        logic start;
        logic stop;
        logic tank_low;
        logic tank_high;
        logic bottle_in;
        logic bottle_full;
    } sense_t;

    // Source place of each transition
    function automatic int tr_src(input int t);
        case (t)
            TR_RESUME:     return PL_IDLE;
            TR_TANK_DONE,
            TR_HALT_TANK:  return PL_TANK;
            TR_HALT_MOTOR,
            TR_TO_FILL:    return PL_MOTOR;
            TR_HALT_FILL,
            TR_TO_MOTOR:   return PL_FILL;
            default:       return PL_RUN;
        endcase
    endfunction

    // Destination place of each transition
    function automatic int tr_dst(input int t);
        case (t)
            TR_TANK_FILL:  return PL_TANK;
            TR_NO_BOTTLE,
            TR_TO_MOTOR:   return PL_MOTOR;
            TR_BOTTLE,
            TR_TO_FILL:    return PL_FILL;
            TR_RESUME,
            TR_TANK_DONE:  return PL_RUN;
            default:       return PL_IDLE;
        endcase
    endfunction

    // Stop-driven transitions are granted ahead of all others
    function automatic logic tr_is_halt(input int t);
        return (t == TR_HALT_RUN)   || (t == TR_HALT_TANK) ||
               (t == TR_HALT_MOTOR) || (t == TR_HALT_FILL);
    endfunction

endpackage

// File: rtl/pn_guard.sv
// Guard evaluation: turns the captured sensor word into one firing
// condition per transition. Stop overrides every ordinary move except the
// return from Idle. Purely combinational; assumes inputs are already held.
module pn_guard
    import pn_pkg::*;
(
    input  sense_t              s,
    output logic [NTRANS-1:0]   guard
);

    // Boolean condition of every transition, stop-priority terms included
    always_comb begin
        guard                = '0;
        guard[TR_RESUME]     = s.start;
        guard[TR_TANK_FILL]  = s.tank_low  & ~s.stop;
        guard[TR_NO_BOTTLE]  = ~s.bottle_in & ~s.stop;
        guard[TR_BOTTLE]     = s.bottle_in & ~s.stop;
        guard[TR_TANK_DONE]  = s.tank_high & ~s.stop;
        guard[TR_TO_FILL]    = s.bottle_in & ~s.bottle_full & ~s.stop;
        guard[TR_TO_MOTOR]   = s.bottle_full & ~s.stop;
        guard[TR_HALT_RUN]   = s.stop;
        guard[TR_HALT_TANK]  = s.stop;
        guard[TR_HALT_MOTOR] = s.stop;
        guard[TR_HALT_FILL]  = s.stop;
    end

endmodule

// File: rtl/pn_arbiter.sv
// Firing arbiter: scans transitions in grant order (stop-driven first,
// then ascending index) and grants each one whose guard is true, whose
// source still has an unclaimed token and whose destination has room,
// counting tokens granted earlier in the same step. Produces the fire
// vector and the marking after the step. Combinational; assumes the
// incoming marking is within capacity.
module pn_arbiter
    import pn_pkg::*;
#(
    parameter int TOKENS = 2,
    parameter int CW     = 2
) (
    input  logic [NPLACE-1:0][CW-1:0] mark,
    input  logic [NTRANS-1:0]         guard,
    output logic [NTRANS-1:0]         fire,
    output logic [NPLACE-1:0][CW-1:0] mark_nxt
);

    // Capacity of a place: the shared places hold every token
    function automatic int place_cap(input int p);
        return ((p == PL_RUN) || (p == PL_IDLE)) ? TOKENS : 1;
    endfunction

    // Single ordered grant pass over all transitions
    always_comb begin : grant_scan
        int rem [NPLACE];
        int inc [NPLACE];
        for (int p = 0; p < NPLACE; p++) begin
            rem[p] = int'(mark[p]);
            inc[p] = 0;
        end
        fire = '0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int t = 0; t < NTRANS; t++) begin
                if ((pass == 0) == tr_is_halt(t)) begin
                    if (guard[t] && (rem[tr_src(t)] > 0) &&
                        (int'(mark[tr_dst(t)]) + inc[tr_dst(t)] < place_cap(tr_dst(t)))) begin
                        fire[t]          = 1'b1;
                        rem[tr_src(t)]   = rem[tr_src(t)] - 1;
                        inc[tr_dst(t)]   = inc[tr_dst(t)] + 1;
                    end
                end
            end
        end
        for (int p = 0; p < NPLACE; p++) begin
            mark_nxt[p] = CW'(rem[p] + inc[p]);
        end
    end

endmodule

// File: rtl/pn_settle_ctrl.sv
// Settling sequencer: alternates a capture cycle with a settling window of
// one firing step per clock. The window closes when a step finds nothing
// to fire, or after LIMIT firing steps, which sets a sticky error.
// Assumes any_fire is valid during the settling phase.
module pn_settle_ctrl #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_fire,
    output logic capture,
    output logic settling,
    output logic timeout_err
);

    localparam int SW = $clog2(LIMIT + 1);

    typedef enum logic {PH_CAPTURE = 1'b0, PH_SETTLE = 1'b1} phase_e;

    phase_e        phase;
    logic [SW-1:0] steps;

    assign capture  = (phase == PH_CAPTURE);
    assign settling = (phase == PH_SETTLE);

    // Phase, step counter and sticky timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_CAPTURE;
            steps       <= '0;
            timeout_err <= 1'b0;
        end else if (phase == PH_CAPTURE) begin
            phase <= PH_SETTLE;
            steps <= '0;
        end else if (any_fire) begin
            if (steps == SW'(LIMIT - 1)) begin
                timeout_err <= 1'b1;
                phase       <= PH_CAPTURE;
            end else begin
                steps <= steps + 1'b1;
            end
        end else begin
            phase <= PH_CAPTURE;
        end
    end

    // R10: once raised, the timeout stays until reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(timeout_err) |-> timeout_err);

    // R10: the step count never passes the window limit
    a_r10_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(steps) < LIMIT);

endmodule

// File: rtl/pn_token_ctrl.sv
// Token marking controller for the bottle-filling net. Captures the
// sensors when the marking is stable, fires one step per clock with the
// captured values frozen, and drives the actuators from the marking only
// when an evaluation finds it stable. Synchronous active-low reset.
module pn_token_ctrl
    import pn_pkg::*;
#(
    parameter int TOKENS = 2,
    parameter int LIMIT  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        stop,
    input  logic                        tank_low,
    input  logic                        tank_high,
    input  logic                        bottle_in,
    input  logic                        bottle_full,
    output logic                        tank_valve,
    output logic                        run_motor,
    output logic                        fill_valve,
    output logic                        settled,
    output logic                        settle_err,
    output logic [NPLACE*$clog2(TOKENS+1)-1:0] tokens
);

    localparam int CW = $clog2(TOKENS + 1);

    sense_t                     held;
    logic [NPLACE-1:0][CW-1:0]  mark;
    logic [NPLACE-1:0][CW-1:0]  mark_nxt;
    logic [NTRANS-1:0]          guard;
    logic [NTRANS-1:0]          fire;
    logic                       any_fire;
    logic                       capture;
    logic                       settling;
    int                         tok_sum;

    assign any_fire = |fire;
    assign tokens   = mark;

    pn_guard u_guard (
        .s     (held),
        .guard (guard)
    );

    pn_arbiter #(.TOKENS(TOKENS), .CW(CW)) u_arb (
        .mark     (mark),
        .guard    (guard),
        .fire     (fire),
        .mark_nxt (mark_nxt)
    );

    pn_settle_ctrl #(.LIMIT(LIMIT)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_fire    (any_fire),
        .capture     (capture),
        .settling    (settling),
        .timeout_err (settle_err)
    );

    // Capture the sensors at the start of each settling window
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (capture) held <= {start, stop, tank_low, tank_high, bottle_in, bottle_full};
    end

    // Marking register: initial marking on reset, one step per firing clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark         <= '0;
            mark[PL_RUN] <= CW'(TOKENS);
        end else if (settling && any_fire) begin
            mark <= mark_nxt;
        end
    end

    // Actuators and settled flag: refreshed only from a stable marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tank_valve <= 1'b0;
            run_motor  <= 1'b0;
            fill_valve <= 1'b0;
            settled    <= 1'b0;
        end else if (settling && !any_fire) begin
            tank_valve <= (mark[PL_TANK]  != '0);
            run_motor  <= (mark[PL_MOTOR] != '0);
            fill_valve <= (mark[PL_FILL]  != '0);
            settled    <= 1'b1;
        end else if (settling) begin
            settled    <= 1'b0;
        end
    end

    // Token total, used only by the conservation check
    always_comb begin
        tok_sum = 0;
        for (int p = 0; p < NPLACE; p++) tok_sum = tok_sum + int'(mark[p]);
    end

    // R2: firing moves tokens, never creates or destroys them
    a_r2_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        tok_sum == TOKENS);

    // R2: single-token places never overflow
    a_r2_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mark[PL_TANK]) <= 1) && (int'(mark[PL_MOTOR]) <= 1) && (int'(mark[PL_FILL]) <= 1));

    // R7: captured inputs stay frozen across consecutive settling steps
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(settling) && settling) |-> $stable(held));

    // R8: actuator outputs move only together with a settled flag
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({tank_valve, run_motor, fill_valve}) |-> settled);

    // R6: with stop captured, ordinary moves other than resume stay idle
    a_r6_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (settling && held.stop) |->
        !(fire[TR_TANK_FILL] || fire[TR_NO_BOTTLE] || fire[TR_BOTTLE] ||
          fire[TR_TANK_DONE] || fire[TR_TO_FILL]   || fire[TR_TO_MOTOR]));

    // R11: the two bottle-dependent moves out of Run are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire[TR_NO_BOTTLE] && fire[TR_BOTTLE]));

endmodule

// File: tb/sim_pn_token_ctrl.sv
// Directed bench for the token marking controller: one task per scenario.
module sim_pn_token_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start, stop, tank_low, tank_high, bottle_in, bottle_full;
    logic       tank_valve, run_motor, fill_valve, settled, settle_err;
    logic [9:0] tokens;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    pn_token_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .start(start), .stop(stop), .tank_low(tank_low), .tank_high(tank_high),
        .bottle_in(bottle_in), .bottle_full(bottle_full),
        .tank_valve(tank_valve), .run_motor(run_motor), .fill_valve(fill_valve),
        .settled(settled), .settle_err(settle_err), .tokens(tokens)
    );

    function automatic logic [9:0] tk(int r, int t, int m, int f, int i);
        return {2'(i), 2'(f), 2'(m), 2'(t), 2'(r)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(bit st, bit sp, bit tl, bit th, bit bi, bit bf);
        @(negedge clk);
        start = st; stop = sp; tank_low = tl; tank_high = th;
        bottle_in = bi; bottle_full = bf;
    endtask

    // R8: while waiting, any actuator change must coincide with settled
    task automatic settle_watch(int n);
        logic [2:0] prev = {tank_valve, run_motor, fill_valve};
        bit bad = 0;
        repeat (n) begin
            @(negedge clk);
            if ({tank_valve, run_motor, fill_valve} != prev && !settled) bad = 1;
            prev = {tank_valve, run_motor, fill_valve};
        end
        check("R8", "outputs changed while unsettled", 32'(bad), 32'd0);
    endtask

    task automatic expect_state(string req, logic [9:0] tok, logic [2:0] outs, bit st);
        check(req, "tokens", 32'(tokens), 32'(tok));
        check("R8", "actuators", 32'({tank_valve, run_motor, fill_valve}), 32'(outs));
        check("R9", "settled", 32'(settled), 32'(st));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "tokens in reset", 32'(tokens), 32'(tk(2,0,0,0,0)));
        check("R1", "outputs in reset", 32'({tank_valve, run_motor, fill_valve, settled, settle_err}), 32'd0);
        rst_n = 1'b1;
    endtask

    // R3 R4 R11: bottle present, one token to BottleFill, second blocked
    task automatic t_bottle();
        settle_watch(40);
        expect_state("R11", tk(1,0,0,1,0), 3'b001, 1'b1);
    endtask

    // R3: tank low sends the spare Run token to TankFill
    task automatic t_tank_low();
        drive(0,0,1,0,1,0);
        settle_watch(40);
        expect_state("R3", tk(0,1,0,1,0), 3'b101, 1'b1);
    endtask

    // R3: bottle full moves the BottleFill token to Motor
    task automatic t_full();
        drive(0,0,1,0,1,1);
        settle_watch(40);
        expect_state("R3", tk(0,1,1,0,0), 3'b110, 1'b1);
    endtask

    // R4: tank high returns a token, it moves on to BottleFill; Motor full blocks the swap
    task automatic t_tank_high();
        drive(0,0,0,1,1,1);
        settle_watch(40);
        expect_state("R4", tk(0,0,1,1,0), 3'b011, 1'b1);
    endtask

    // R5: two stop moves share the Idle capacity in one step
    task automatic t_stop();
        drive(0,1,0,1,1,1);
        settle_watch(40);
        expect_state("R5", tk(0,0,0,0,2), 3'b000, 1'b1);
    endtask

    // R7: start needs several steps: resume, then resume plus no-bottle move
    task automatic t_restart();
        drive(1,0,0,0,0,0);
        settle_watch(40);
        expect_state("R7", tk(1,0,1,0,0), 3'b010, 1'b1);
        drive(0,0,1,0,0,0);
        settle_watch(40);
        expect_state("R3", tk(0,1,1,0,0), 3'b110, 1'b1);
    endtask

    // R6: stop and tank high together; stop wins on TankFill
    task automatic t_stop_priority();
        drive(0,1,0,1,0,0);
        settle_watch(40);
        expect_state("R6", tk(0,0,0,0,2), 3'b000, 1'b1);
    endtask

    // R10: tank low and high together ping-pong forever; timeout, outputs kept
    task automatic t_timeout();
        drive(1,0,1,1,1,0);
        settle_watch(60);
        check("R10", "settle_err", 32'(settle_err), 32'd1);
        check("R10", "outputs kept", 32'({tank_valve, run_motor, fill_valve}), 32'd0);
        check("R9", "settled low while looping", 32'(settled), 32'd0);
        drive(0,0,0,0,1,0);
        settle_watch(60);
        check("R10", "settle_err sticky", 32'(settle_err), 32'd1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "err cleared by reset", 32'(settle_err), 32'd0);
        check("R1", "tokens after reset", 32'(tokens), 32'(tk(2,0,0,0,0)));
        rst_n = 1'b1;
    endtask

    initial begin
        start = 0; stop = 0; tank_low = 0; tank_high = 0; bottle_in = 1; bottle_full = 0;
        t_reset();
        t_bottle();
        t_tank_low();
        t_full();
        t_tank_high();
        t_stop();
        t_restart();
        t_stop_priority();
        t_timeout();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule